// File: doc/BRIEF.md
# Multi-Domain Reset Sequencer

This block coordinates reset for a network MAC that spans three clocks: a host bus clock, a transmit clock and a receive clock. It accepts an asynchronous power-up reset and a software reset request, and merges them into a single global reset request. That request drives three separate synchronizers, one per clock domain. Each per-domain reset asserts at once, without waiting for a clock, and deasserts only on an edge of its own clock.

Around the reset pulse the block runs a quiesce sequence. First it lowers a port-enable output so that no traffic enters from either side. After a fixed drain time it asserts reset in every domain and holds it for a minimum number of host cycles. It then releases reset and waits until the transmit and receive domains report, through synchronizers back into the host domain, that they are out of reset. Only then does it raise port-enable again. This way no domain starts working before the others.

The software request bit lives inside the block. A host write pulse sets it, and it clears itself at the moment the ports reopen. A done flag tells the host that the sequence has completed.

Top module: `mac_rst_seq`

## Requirements
- R1: While `por_rst` is high, `host_rst`, `tx_rst` and `rx_rst` are high, and `port_en`, `sw_rst_bit` and `seq_done` are low. The three resets rise asynchronously, with no clock edge needed.
- R2: After `por_rst` falls on a host clock falling edge, `host_rst` stays high for exactly HOLD_CYC+1 further host cycles. After that the ports open once all domains have been released.
- R3: `port_en` is never high while any of `host_rst`, `tx_rst` or `rx_rst` is high. It rises only after all three are low.
- R4: A one-cycle `sw_rst_set` pulse while the ports are open sets `sw_rst_bit` and clears `seq_done` at the next host edge. `port_en` falls one host edge later.
- R5: After `port_en` falls, the three resets stay low for exactly CLOSE_CYC host cycles. They then assert together.
- R6: In a software sequence, `host_rst` is high for exactly HOLD_CYC+2 host cycles. This is HOLD_CYC cycles of the held request plus two cycles of synchronizer release.
- R7: `tx_rst` and `rx_rst` fall only on a rising edge of their own clock, `tx_clk` and `rx_clk` respectively.
- R8: On the host edge where `port_en` rises, `sw_rst_bit` clears and `seq_done` sets.
- R9: `sw_rst_set` has no effect while `por_rst` is high (the bit stays 0). It also has no effect while a sequence is in progress: the sequence is not lengthened or restarted.
- R10: Raising `por_rst` in the middle of a sequence immediately forces all resets high, `port_en` low and `sw_rst_bit` low.
- R11: If one domain's clock stops while its reset is asserted, `port_en` stays low and that domain's reset stays high. The ports open once the clock resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| host_clk | input | 1 | Host bus clock; the sequencer runs on it |
| tx_clk | input | 1 | Transmit domain clock |
| rx_clk | input | 1 | Receive domain clock |
| por_rst | input | 1 | Asynchronous power-up reset, active high |
| sw_rst_set | input | 1 | Host write pulse that sets the software reset bit |
| sw_rst_bit | output | 1 | Software reset request bit; clears itself at reopen |
| seq_done | output | 1 | High once a reset sequence has completed |
| port_en | output | 1 | Port enable; low closes both traffic directions |
| host_rst | output | 1 | Host domain reset, active high |
| tx_rst | output | 1 | Transmit domain reset, active high |
| rx_rst | output | 1 | Receive domain reset, active high |

## Verification
The hardest state to reach is the one where a single domain is still held in reset while the others have already been released. Only this state shows that reopening truly waits for the slowest domain. The bench produces it by stopping the receive clock after the resets have asserted. It then confirms that the ports stay closed and `rx_rst` stays high for many host cycles, and finally restarts the clock and waits for the reopen. A table of transmit and receive half-periods also runs the same software sequence under fast, slow and equal clock ratios, so the release-edge alignment and the exact close and hold windows are measured against several phase relationships.

// File: rtl/mac_rst_seq.sv
`timescale 1ns/1ps
module mac_rst_seq #(
  parameter int HOLD_CYC  = 8,
  parameter int CLOSE_CYC = 4
) (
  input  logic host_clk,
  input  logic tx_clk,
  input  logic rx_clk,
  input  logic por_rst,
  input  logic sw_rst_set,
  output logic sw_rst_bit,
  output logic seq_done,
  output logic port_en,
  output logic host_rst,
  output logic tx_rst,
  output logic rx_rst
);

  localparam int MAXC = (HOLD_CYC > CLOSE_CYC) ? HOLD_CYC : CLOSE_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int ND   = 3;

  typedef enum logic [1:0] {ST_RUN, ST_CLOSE, ST_HOLD, ST_WAIT} seq_t;

  seq_t          state, state_n;
  logic [CW-1:0] cnt;
  logic          rst_req_q;
  logic          greq;
  logic [ND-1:0] dclk, drst, ack;

  assign greq = por_rst | rst_req_q;
  assign dclk = {rx_clk, tx_clk, host_clk};
  assign host_rst = drst[0];
  assign tx_rst   = drst[1];
  assign rx_rst   = drst[2];

  for (genvar g = 0; g < ND; g++) begin : g_dom
    logic [1:0] sh;
    always_ff @(posedge dclk[g] or posedge greq)
      if (greq) sh <= 2'b11;
      else      sh <= {sh[0], 1'b0};
    assign drst[g] = sh[1];

    if (g == 0) begin : g_local
      assign ack[g] = ~drst[g];
    end else begin : g_back
      logic [1:0] ak;
      always_ff @(posedge host_clk or posedge greq)
        if (greq) ak <= 2'b00;
        else      ak <= {ak[0], ~drst[g]};
      assign ack[g] = ak[1];
    end
  end

  always_comb begin
    state_n = state;
    unique case (state)
      ST_RUN:   if (sw_rst_bit) state_n = ST_CLOSE;
      ST_CLOSE: if (cnt == CW'(CLOSE_CYC - 1)) state_n = ST_HOLD;
      ST_HOLD:  if (cnt == CW'(HOLD_CYC - 1)) state_n = ST_WAIT;
      ST_WAIT:  if (&ack) state_n = ST_RUN;
      default:  state_n = ST_HOLD;
    endcase
  end

  wire enter_run = (state_n == ST_RUN) && (state != ST_RUN);
  wire take_set  = sw_rst_set && (state == ST_RUN) && !sw_rst_bit;

  always_ff @(posedge host_clk or posedge por_rst)
    if (por_rst) begin
      state      <= ST_HOLD;
      cnt        <= '0;
      rst_req_q  <= 1'b1;
      port_en    <= 1'b0;
      sw_rst_bit <= 1'b0;
      seq_done   <= 1'b0;
    end else begin
      state     <= state_n;
      cnt       <= (state_n != state) ? '0 : cnt + 1'b1;
      rst_req_q <= (state_n == ST_HOLD);
      port_en   <= (state_n == ST_RUN);
      if (enter_run)     sw_rst_bit <= 1'b0;
      else if (take_set) sw_rst_bit <= 1'b1;
      if (enter_run)     seq_done <= 1'b1;
      else if (take_set) seq_done <= 1'b0;
    end

  a_r3_open_needs_release: assert property (@(posedge host_clk) disable iff (por_rst)
    port_en |-> (ack == 3'b111) && !rst_req_q);

  a_r5_closed_before_reset: assert property (@(posedge host_clk) disable iff (por_rst)
    $rose(rst_req_q) |-> !port_en);

  a_r4_close_on_request: assert property (@(posedge host_clk) disable iff (por_rst)
    (port_en && sw_rst_bit) |=> !port_en);

  a_r8_clear_at_reopen: assert property (@(posedge host_clk) disable iff (por_rst)
    $rose(port_en) |-> (!sw_rst_bit && seq_done));

  a_r9_bit_held_to_reopen: assert property (@(posedge host_clk) disable iff (por_rst)
    $fell(sw_rst_bit) |-> $rose(port_en));

  a_r11_wait_slowest: assert property (@(posedge host_clk) disable iff (por_rst)
    (state == ST_WAIT && ack != 3'b111) |=> !port_en);

endmodule

// File: tb/mac_rst_seq_test.sv
`timescale 1ns/1ps
module mac_rst_seq_test;
  localparam int HOLD  = 8;
  localparam int CLOSE = 4;
  localparam int NV    = 4;
  localparam int TXH[NV] = '{5, 3, 13, 20};
  localparam int RXH[NV] = '{7, 11, 4, 20};

  logic host_clk = 0, tx_clk = 0, rx_clk = 0;
  logic por_rst = 0, sw_rst_set = 0;
  logic sw_rst_bit, seq_done, port_en, host_rst, tx_rst, rx_rst;

  int txh = 5, rxh = 7;
  bit rx_run = 1;
  int n_tests = 0, n_fail = 0;
  int ovl = 0, mis = 0;
  time t_tx = 0, t_rx = 0;

  mac_rst_seq #(.HOLD_CYC(HOLD), .CLOSE_CYC(CLOSE)) uut (
    .host_clk(host_clk), .tx_clk(tx_clk), .rx_clk(rx_clk),
    .por_rst(por_rst), .sw_rst_set(sw_rst_set),
    .sw_rst_bit(sw_rst_bit), .seq_done(seq_done), .port_en(port_en),
    .host_rst(host_rst), .tx_rst(tx_rst), .rx_rst(rx_rst));

  always #4 host_clk = ~host_clk;
  always begin #(txh); tx_clk = ~tx_clk; end
  always begin
    if (rx_run) begin #(rxh); rx_clk = ~rx_clk; end
    else #1;
  end

  always @(posedge tx_clk) t_tx = $time;
  always @(posedge rx_clk) t_rx = $time;
  always @(negedge tx_rst) if ($time != t_tx) mis++;
  always @(negedge rx_rst) if ($time != t_rx) mis++;
  always @(negedge host_clk) if (port_en && (host_rst || tx_rst || rx_rst)) ovl++;

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_sw();
    @(negedge host_clk) sw_rst_set = 1;
    @(negedge host_clk) sw_rst_set = 0;
  endtask

  task automatic wait_open(output int cyc);
    cyc = 0;
    while (!port_en && cyc < 3000) begin
      @(negedge host_clk);
      cyc++;
    end
  endtask

  task automatic wait_rst(output int cyc);
    cyc = 0;
    while (!host_rst && cyc < 3000) begin
      @(negedge host_clk);
      cyc++;
    end
  endtask

  initial begin : watchdog
    #1_000_000;
    n_fail++;
    $display("FAIL R3 watchdog actual=hung expected=complete");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    int c, gap, hc;
    #2 por_rst = 1;
    repeat (5) @(negedge host_clk);
    chk("R1 host_rst", host_rst, 1);
    chk("R1 tx_rst", tx_rst, 1);
    chk("R1 rx_rst", rx_rst, 1);
    chk("R1 port_en", port_en, 0);
    chk("R1 seq_done", seq_done, 0);
    pulse_sw();
    @(negedge host_clk);
    chk("R9 set ignored in por", sw_rst_bit, 0);

    por_rst = 0;
    hc = 0;
    @(negedge host_clk);
    while (host_rst && hc < 3000) begin hc++; @(negedge host_clk); end
    chk("R2 hold after por", hc, HOLD + 1);
    wait_open(c);
    chk("R2 opened after por", port_en, 1);
    chk("R3 all released at open", tx_rst | rx_rst | host_rst, 0);

    for (int v = 0; v < NV; v++) begin
      txh = TXH[v];
      rxh = RXH[v];
      repeat (10) @(negedge host_clk);
      pulse_sw();
      chk("R4 bit set", sw_rst_bit, 1);
      chk("R4 done cleared", seq_done, 0);
      chk("R4 still open one edge", port_en, 1);
      @(negedge host_clk);
      chk("R4 port closed", port_en, 0);
      gap = 0;
      while (!host_rst && gap < 3000) begin
        if (tx_rst || rx_rst) gap += 100;
        gap++;
        @(negedge host_clk);
      end
      chk("R5 close window", gap, CLOSE);
      chk("R5 tx asserted with host", tx_rst, 1);
      chk("R5 rx asserted with host", rx_rst, 1);
      hc = 0;
      while (host_rst && hc < 3000) begin hc++; @(negedge host_clk); end
      chk("R6 host reset width", hc, HOLD + 2);
      wait_open(c);
      chk("R8 reopened", port_en, 1);
      chk("R8 bit self-cleared", sw_rst_bit, 0);
      chk("R8 done set", seq_done, 1);
      chk("R3 no reset at reopen", tx_rst | rx_rst, 0);
    end
    chk("R3 never open during reset", ovl, 0);
    chk("R7 release edge alignment", mis, 0);

    txh = 5; rxh = 9;
    repeat (5) @(negedge host_clk);
    pulse_sw();
    wait_rst(c);
    rx_run = 0;
    repeat (60) @(negedge host_clk);
    chk("R11 ports held closed", port_en, 0);
    chk("R11 stalled rx in reset", rx_rst, 1);
    chk("R11 tx released", tx_rst, 0);
    rx_run = 1;
    wait_open(c);
    chk("R11 opened after resume", port_en, 1);

    repeat (5) @(negedge host_clk);
    pulse_sw();
    wait_rst(c);
    hc = 0;
    while (host_rst && hc < 3000) begin
      hc++;
      sw_rst_set = (hc >= 2 && hc < 5);
      @(negedge host_clk);
    end
    sw_rst_set = 0;
    chk("R9 width unchanged by rewrite", hc, HOLD + 2);
    wait_open(c);
    hc = 0;
    repeat (40) begin
      @(negedge host_clk);
      if (host_rst || !port_en) hc++;
    end
    chk("R9 no restart", hc, 0);
    chk("R9 bit clear", sw_rst_bit, 0);

    repeat (5) @(negedge host_clk);
    pulse_sw();
    wait_rst(c);
    @(negedge host_clk);
    por_rst = 1;
    #1;
    chk("R10 port closed", port_en, 0);
    chk("R10 bit cleared", sw_rst_bit, 0);
    chk("R10 resets high", {host_rst, tx_rst, rx_rst}, 7);
    @(negedge host_clk);
    por_rst = 0;
    wait_open(c);
    chk("R10 recovers", port_en, 1);
    chk("R7 release edge alignment final", mis, 0);
    chk("R3 overlap final", ovl, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule